// File: doc/BRIEF.md
# Event Interrupt and Soft-Reset Controller

This block sits beside a serial-port core and turns that core's single-cycle event pulses into one level-sensitive interrupt request. Each of seven event sources latches into a sticky status bit. A per-source mask and a global enable decide whether a latched event raises the interrupt line. Software acknowledges events by writing ones to the status register, usually writing back the value it has just read.

The same register port holds a soft-reset register. A write of one fixed key value produces a reset pulse of fixed width for the attached core. Any other value is ignored. While the pulse is high, the status and mask registers are forced to zero. The global enable keeps its value.

All registers sit behind a plain 32-bit write/read port with a byte address. A write takes effect on the clock edge at which `reg_wr` is high. Read data is a combinational function of `reg_addr`.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After `rst_n` is released, the global enable, status and mask registers all read zero, and `irq` and `core_rst` are low.
- R2: A pulse on `evt_pulse[i]` sets status bit i at offset 0x20 on that clock edge, whatever the mask holds. The bit order is: 0 mode fault, 1 slave mode fault, 2 transmit empty, 3 transmit underrun, 4 receive full, 5 receive overrun, 6 transmit half empty.
- R3: A write to offset 0x20 clears each status bit whose written bit is one and leaves the other bits unchanged. Writing back a value that was read acknowledges exactly those events.
- R4: If an event pulse and a clearing write hit the same status bit on the same edge, the bit ends up set.
- R5: The mask register at offset 0x28 can be written and read back in bits 6:0. Its bits above 6 read as zero.
- R6: The global enable is bit 31 of offset 0x1C, and the other bits of that offset read as zero. While the global enable is zero, `irq` stays low.
- R7: `irq` equals the global enable ANDed with the OR over all sources of (status AND mask), as the registers stood one clock earlier.
- R8: Writing exactly 0x0000000A to offset 0x40 drives `core_rst` high for exactly 4 cycles, starting on the edge of the write.
- R9: A write of any other value to offset 0x40, or any key write while `core_rst` is high, leaves `core_rst` unchanged.
- R10: The valid key write and every cycle with `core_rst` high force the status and mask registers to zero. Event pulses and mask or status writes in those cycles are discarded. The global enable keeps its value.
- R11: Reads of offset 0x40 and of any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Byte offset for reads and writes |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_pulse | input | 7 | One-cycle event pulses from the core |
| irq | output | 1 | Level interrupt request |
| core_rst | output | 1 | Reset pulse to the attached core |

## Verification
The hardest cases to reach from the ports are the collisions on one edge. One is an event pulse landing on the same status bit that a clearing write names. The other is events, mask writes and repeated key writes arriving while the reset pulse is already running. Directed sequences place these on exact cycles. A long seeded random phase then mixes sparse event bursts with writes that favour the mapped offsets and often carry the reset key, so these overlaps keep recurring. A cycle-level model in the bench predicts every read, `irq` and `core_rst` on every cycle.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  // register byte offsets; software depends on these values
  localparam int unsigned OFS_GLOBAL = 'h1C;
  localparam int unsigned OFS_STATUS = 'h20;
  localparam int unsigned OFS_MASK   = 'h28;
  localparam int unsigned OFS_SRESET = 'h40;

  // value that fires the soft reset
  localparam logic [31:0] SRESET_KEY = 32'h0000_000A;

  // bit of the global-enable register that gates the interrupt
  localparam int unsigned GLOBAL_BIT = 31;

  // event source bit positions
  typedef enum int unsigned {
    SRC_MODE_FAULT  = 0,
    SRC_SLAVE_FAULT = 1,
    SRC_TX_EMPTY    = 2,
    SRC_TX_UNDERRUN = 3,
    SRC_RX_FULL     = 4,
    SRC_RX_OVERRUN  = 5,
    SRC_TX_HALF     = 6
  } evt_src_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_GLOBAL,
    SEL_STATUS,
    SEL_MASK,
    SEL_SRESET
  } reg_sel_e;
endpackage

// File: rtl/evt_reg_decode.sv
module evt_reg_decode
  import evt_irq_pkg::*;
#(
  parameter int unsigned AW   = 8,
  parameter int unsigned DW   = 32,
  parameter int unsigned NSRC = 7
) (
  input  logic [AW-1:0]   addr,
  input  logic            wr,
  input  logic [DW-1:0]   wdata,
  input  logic            core_rst,
  input  logic            glb_en,
  input  logic [NSRC-1:0] stat,
  input  logic [NSRC-1:0] mask,
  output logic            glb_we,
  output logic            mask_we,
  output logic [NSRC-1:0] clr_vec,
  output logic            key_hit,
  output logic [DW-1:0]   rdata
);
  reg_sel_e sel;

  function automatic reg_sel_e decode(input logic [AW-1:0] a);
    if (a == AW'(OFS_GLOBAL)) return SEL_GLOBAL;
    if (a == AW'(OFS_STATUS)) return SEL_STATUS;
    if (a == AW'(OFS_MASK))   return SEL_MASK;
    if (a == AW'(OFS_SRESET)) return SEL_SRESET;
    return SEL_NONE;
  endfunction

  function automatic logic is_key(input logic [DW-1:0] d);
    return d == DW'(SRESET_KEY);
  endfunction

  assign sel     = decode(addr);
  assign glb_we  = wr && (sel == SEL_GLOBAL);
  assign mask_we = wr && (sel == SEL_MASK);
  assign clr_vec = (wr && sel == SEL_STATUS) ? wdata[NSRC-1:0] : '0;
  assign key_hit = wr && (sel == SEL_SRESET) && is_key(wdata) && !core_rst;

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_GLOBAL: rdata[GLOBAL_BIT] = glb_en;
      SEL_STATUS: rdata[NSRC-1:0]   = stat;
      SEL_MASK:   rdata[NSRC-1:0]   = mask;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_stat_bank.sv
module evt_stat_bank #(
  parameter int unsigned NSRC = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_clear,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] clr_vec,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  output logic [NSRC-1:0] stat_q,
  output logic [NSRC-1:0] mask_q
);
  // an event takes priority over a clear of the same bit
  function automatic logic next_bit(input logic cur, input logic clr, input logic ev);
    return (cur & ~clr) | ev;
  endfunction

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n || hold_clear) stat_q[i] <= 1'b0;
      else                      stat_q[i] <= next_bit(stat_q[i], clr_vec[i], evt[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hold_clear) mask_q <= '0;
    else if (mask_we)         mask_q <= mask_wdata;
  end
endmodule

// File: rtl/evt_srst_pulse.sv
module evt_srst_pulse #(
  parameter int unsigned WIDTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_hit,
  output logic core_rst
);
  localparam int unsigned CW = $clog2(WIDTH + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (key_hit)        cnt_q <= CW'(WIDTH);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign core_rst = (cnt_q != '0);
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 32,
  parameter int unsigned NSRC      = 7,
  parameter int unsigned RST_PULSE = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_wr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NSRC-1:0] evt_pulse,
  output logic            irq,
  output logic            core_rst
);
  logic            glb_en_q;
  logic [NSRC-1:0] stat_q;
  logic [NSRC-1:0] mask_q;
  logic            glb_we;
  logic            mask_we;
  logic [NSRC-1:0] clr_vec;
  logic            key_hit;
  logic            hold_clear;
  logic            irq_q;

  function automatic logic irq_level(input logic g, input logic [NSRC-1:0] s,
                                     input logic [NSRC-1:0] m);
    return g & (|(s & m));
  endfunction

  evt_reg_decode #(.AW(AW), .DW(DW), .NSRC(NSRC)) u_dec (
    .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata), .core_rst(core_rst),
    .glb_en(glb_en_q), .stat(stat_q), .mask(mask_q),
    .glb_we(glb_we), .mask_we(mask_we), .clr_vec(clr_vec),
    .key_hit(key_hit), .rdata(reg_rdata)
  );

  assign hold_clear = key_hit | core_rst;

  evt_stat_bank #(.NSRC(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .hold_clear(hold_clear), .evt(evt_pulse),
    .clr_vec(clr_vec), .mask_we(mask_we), .mask_wdata(reg_wdata[NSRC-1:0]),
    .stat_q(stat_q), .mask_q(mask_q)
  );

  evt_srst_pulse #(.WIDTH(RST_PULSE)) u_srst (
    .clk(clk), .rst_n(rst_n), .key_hit(key_hit), .core_rst(core_rst)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      glb_en_q <= 1'b0;
    else if (glb_we) glb_en_q <= reg_wdata[GLOBAL_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_level(glb_en_q, stat_q, mask_q);
  end

  assign irq = irq_q;
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk
  import evt_irq_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 32,
  parameter int unsigned NSRC      = 7,
  parameter int unsigned RST_PULSE = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   reg_addr,
  input logic            reg_wr,
  input logic [DW-1:0]   reg_wdata,
  input logic [NSRC-1:0] evt_pulse,
  input logic            irq,
  input logic            core_rst,
  input logic            glb_en_q,
  input logic [NSRC-1:0] stat_q,
  input logic [NSRC-1:0] mask_q,
  input logic            key_hit
);
  localparam int unsigned RW = $clog2(RST_PULSE + 2);

  logic [RW-1:0]   run_q;
  logic            stat_wr;
  logic [NSRC-1:0] keep_bits;
  logic [NSRC-1:0] both_bits;

  always_ff @(posedge clk) begin
    if (!rst_n || !core_rst) run_q <= '0;
    else                     run_q <= run_q + 1'b1;
  end

  assign stat_wr   = reg_wr && (reg_addr == AW'(OFS_STATUS)) && !core_rst && !key_hit;
  assign keep_bits = stat_q & ~reg_wdata[NSRC-1:0];
  assign both_bits = evt_pulse & reg_wdata[NSRC-1:0];

  AST_EVT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse && !core_rst && !key_hit) |=> ((stat_q & $past(evt_pulse)) == $past(evt_pulse))); // R2
  AST_CLEAR_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((stat_q & $past(keep_bits)) == $past(keep_bits))); // R3
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && |both_bits) |=> ((stat_q & $past(both_bits)) == $past(both_bits))); // R4
  AST_IRQ_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(glb_en_q)); // R6
  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en_q && |(stat_q & mask_q)) |=> irq); // R7
  AST_KEY_STARTS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> core_rst); // R8
  AST_PULSE_NOT_TOO_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (run_q < RW'(RST_PULSE))); // R8
  AST_PULSE_FULL_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> (run_q == RW'(RST_PULSE))); // R8
  AST_PULSE_ONLY_FROM_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst) |-> $past(key_hit)); // R9
  AST_RESET_ZEROES_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (stat_q == '0 && mask_q == '0)); // R10
  AST_RESET_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst && !(reg_wr && reg_addr == AW'(OFS_GLOBAL))) |=> $stable(glb_en_q)); // R10
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
  .AW(AW), .DW(DW), .NSRC(NSRC), .RST_PULSE(RST_PULSE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .evt_pulse(evt_pulse), .irq(irq), .core_rst(core_rst),
  .glb_en_q(glb_en_q), .stat_q(stat_q), .mask_q(mask_q), .key_hit(key_hit)
);

// File: tb/evt_irq_ctrl_test.sv
module evt_irq_ctrl_test;
  localparam int LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [6:0]  evt_pulse = '0;
  logic        irq;
  logic        core_rst;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // bench model
  bit       m_gie;
  bit [6:0] m_stat;
  bit [6:0] m_mask;
  int       m_cnt;
  bit       m_irq;

  always #10 clk = ~clk;  // 50 MHz

  evt_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .irq(irq), .core_rst(core_rst)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > LIMIT) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cycles, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h1C:   return {m_gie, 31'b0};
      8'h20:   return {25'b0, m_stat};
      8'h28:   return {25'b0, m_mask};
      default: return 32'b0;
    endcase
  endfunction

  function automatic string read_tag(input logic [7:0] a);
    case (a)
      8'h1C:   return "R6";
      8'h20:   return "R2";
      8'h28:   return "R5";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit key, hold, nirq;
    key  = reg_wr && reg_addr == 8'h40 && reg_wdata == 32'h0A && m_cnt == 0;
    hold = key || (m_cnt != 0);
    nirq = m_gie && |(m_stat & m_mask);
    if (reg_wr && reg_addr == 8'h1C) m_gie = reg_wdata[31];
    if (hold) begin
      m_stat = '0;
      m_mask = '0;
    end else begin
      if (reg_wr && reg_addr == 8'h20) m_stat = m_stat & ~reg_wdata[6:0];
      m_stat = m_stat | evt_pulse;
      if (reg_wr && reg_addr == 8'h28) m_mask = reg_wdata[6:0];
    end
    if (key) m_cnt = 4;
    else if (m_cnt > 0) m_cnt = m_cnt - 1;
    m_irq = nirq;
  endtask

  // called at a falling edge; drives one cycle and checks all outputs
  task automatic cyc(input bit wr, input logic [7:0] a, input logic [31:0] d,
                     input logic [6:0] ev, input string tag);
    reg_wr = wr; reg_addr = a; reg_wdata = d; evt_pulse = ev;
    #1;
    check(tag, reg_rdata, exp_read(a));
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R7", {31'b0, irq}, {31'b0, m_irq});
    check("R8", {31'b0, core_rst}, {31'b0, (m_cnt != 0)});
    reg_wr = 1'b0; evt_pulse = '0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    cyc(1'b0, a, 32'h0, 7'h0, tag);
  endtask

  initial begin
    logic [31:0] snap;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd(8'h1C, "R1"); rd(8'h20, "R1"); rd(8'h28, "R1");
    check("R1", {30'b0, irq, core_rst}, 32'b0);
    // R11 soft-reset register and holes read zero
    rd(8'h40, "R11"); rd(8'h04, "R11");
    // R5 mask width
    cyc(1'b1, 8'h28, 32'hFFFF_FFFF, 7'h0, "R5");
    rd(8'h28, "R5");
    cyc(1'b1, 8'h28, 32'h0000_0004, 7'h0, "R5");
    // R6 global enable only bit 31
    cyc(1'b1, 8'h1C, 32'h7FFF_FFFF, 7'h0, "R6");
    rd(8'h1C, "R6");
    // R2 event latches though mask is clear for it; R6 no irq with gie off
    cyc(1'b0, 8'h20, 32'h0, 7'h44, "R2");
    rd(8'h20, "R2");
    rd(8'h20, "R6");
    check("R6", {31'b0, irq}, 32'b0);
    // R7 enabling global raises irq one cycle later
    cyc(1'b1, 8'h1C, 32'h8000_0000, 7'h0, "R7");
    rd(8'h1C, "R7");
    check("R7", {31'b0, irq}, 32'b1);
    // R4 event and clear on same bit
    cyc(1'b1, 8'h20, 32'h0000_0004, 7'h04, "R4");
    rd(8'h20, "R4");
    // R3 read then write back acknowledges exactly those bits
    cyc(1'b0, 8'h20, 32'h0, 7'h09, "R3");
    snap = reg_rdata;
    cyc(1'b1, 8'h20, 32'h0000_0004, 7'h0, "R3");
    rd(8'h20, "R3");
    snap = reg_rdata;
    cyc(1'b1, 8'h20, snap, 7'h0, "R3");
    rd(8'h20, "R3");
    check("R3", reg_rdata, 32'h0);
    // R9 wrong keys ignored
    cyc(1'b1, 8'h40, 32'h0000_000B, 7'h0, "R9");
    cyc(1'b1, 8'h40, 32'h0000_010A, 7'h0, "R9");
    check("R9", {31'b0, core_rst}, 32'b0);
    // R8 / R10 valid key
    cyc(1'b0, 8'h20, 32'h0, 7'h7F, "R10");
    cyc(1'b1, 8'h28, 32'h7F, 7'h0, "R10");
    cyc(1'b1, 8'h40, 32'h0000_000A, 7'h0, "R8");
    check("R8", {31'b0, core_rst}, 32'b1);
    cyc(1'b1, 8'h28, 32'h7F, 7'h7F, "R10");
    cyc(1'b1, 8'h40, 32'h0000_000A, 7'h7F, "R9");
    rd(8'h20, "R10");
    rd(8'h1C, "R10");
    rd(8'h28, "R10");
    check("R8", {31'b0, core_rst}, 32'b0);
    // seeded random phase
    for (int i = 0; i < 6000; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic [6:0]  ev;
      bit          w;
      case ($urandom % 6)
        0: a = 8'h1C;
        1, 2: a = 8'h20;
        3: a = 8'h28;
        4: a = 8'h40;
        default: a = 8'($urandom);
      endcase
      d  = $urandom;
      if (a == 8'h40 && ($urandom % 4) == 0) d = 32'h0A;
      if (a == 8'h20 && ($urandom % 2) == 0) d = exp_read(8'h20);
      w  = ($urandom % 3) == 0;
      ev = (($urandom % 4) == 0) ? 7'($urandom) : 7'h0;
      cyc(w, a, d, ev, read_tag(a));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule